// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a 32768 Hz time base into a programmable periodic interrupt. The time base arrives as a one-cycle enable strobe in the system clock domain, and a free-running 15-bit prescaler counts those strobes. A 4-bit rate code selects a power-of-two period. A tick fires whenever the prescaler count steps onto a multiple of that period, so ticks always stay aligned to the prescaler. They are never timed from the moment the code was written.

Each tick pulses `flagSet` for one system clock. The same tick sets `irqReq`, which stays high until the surrounding register logic clears it with `irqClear`. A 3-bit divider control either runs the prescaler, freezes it, or clears it and holds it at zero. The periodic enable bit gates the ticks without stopping the prescaler.

Top module: `pid_periodic_divider`

## Requirements
- R1: A rate code of 0 produces no tick, no flag pulse and no interrupt request.
- R2: For rate codes 3 to 15 the period is 2^(code-1) strobes of the time base. After the prescaler is released from zero, the first tick follows exactly that many strobes.
- R3: Rate code 1 gives a period of 128 strobes and rate code 2 gives 256 strobes.
- R4: A tick fires only on a strobe that brings the prescaler count to a multiple of the selected period. The count is the number of strobes since the prescaler was last cleared, taken modulo 32768.
- R5: While `periodicEnable` is 0 there are no ticks, but the prescaler keeps counting. Once enabled, the next tick lands on the next multiple of the period.
- R6: A tick raises `flagSet` in the same cycle and sets `irqReq`. `irqReq` stays high until a cycle with `irqClear` at 1. If a tick and a clear arrive together, the set wins.
- R7: After a rate code change, the next tick comes at the next multiple of the new period. No tick is produced out of alignment.
- R8: While `divCtl[2:1]` is 2'b11, the prescaler is cleared and held at zero and no tick is produced.
- R9: A tick lasts exactly one system clock and appears in the cycle after the strobe cycle that caused it.
- R10: After reset, `tick`, `flagSet` and `irqReq` are 0.
- R11: When `divCtl` is 3'b011, 3'b100 or 3'b101, the prescaler is frozen at its count and no tick is produced. Returning to 3'b000..3'b010 resumes counting from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseStrobe | input | 1 | One-cycle enable at the 32768 Hz base rate |
| rateCode | input | 4 | Period select code |
| periodicEnable | input | 1 | Gates the periodic ticks |
| divCtl | input | 3 | Divider control: run, freeze or hold in reset |
| irqClear | input | 1 | Clears the interrupt request |
| tick | output | 1 | One-cycle periodic tick |
| flagSet | output | 1 | One-cycle pulse to set the periodic and master flags |
| irqReq | output | 1 | Interrupt request, held until cleared |

## Verification
On every cycle the assertions check the following:
- A tick lasts one cycle and follows a strobe.
- Every tick carries the flag pulse and the interrupt request.
- The request holds until it is cleared.
- A zero code, a cleared enable, a frozen divider or a held divider blocks the next tick.

Only the bench scenarios can show the period itself for each code, the remapping of codes 1 and 2, and alignment to multiples after an enable or a code change. The same applies to the freeze preserving the count across divider modes, since each of these needs hundreds or thousands of strobes of history.

// File: rtl/pid_pkg.sv
package pid_pkg;

  // Width of the free-running prescaler (one full second at 32768 Hz)
  localparam int PRESCALE_W = 15;
  localparam int RATE_W     = 4;
  localparam int DIVCTL_W   = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic countClr;
  } presc_ctrl_t;

endpackage

// File: rtl/pid_prescaler.sv
module pid_prescaler
  import pid_pkg::*;
#(
  parameter int CNT_W = PRESCALE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  presc_ctrl_t      ctrl,
  output logic [CNT_W:0]   boundary
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] nextCount;

  assign nextCount = count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctrl.countClr) begin
      count <= '0;
    end else if (ctrl.countEn) begin
      count <= nextCount;
    end
  end

  // boundary[b]: the next count is a multiple of 2^b
  assign boundary[0] = 1'b1;
  for (genvar b = 1; b <= CNT_W; b++) begin : g_bnd
    assign boundary[b] = (nextCount[b-1:0] == '0);
  end

endmodule

// File: rtl/pid_control.sv
module pid_control
  import pid_pkg::*;
#(
  parameter int CNT_W  = PRESCALE_W,
  parameter int CODE_W = RATE_W,
  parameter int DCTL_W = DIVCTL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseStrobe,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              periodicEnable,
  input  logic [DCTL_W-1:0] divCtl,
  input  logic              irqClear,
  input  logic [CNT_W:0]    boundary,
  output presc_ctrl_t       ctrl,
  output logic              tick,
  output logic              flagSet,
  output logic              irqReq
);

  localparam logic [CODE_W-1:0] REMAP_LO = CODE_W'(8);
  localparam logic [CODE_W-1:0] REMAP_HI = CODE_W'(9);
  localparam logic [DCTL_W-1:0] RUN_MAX  = DCTL_W'(2);

  logic [CODE_W-1:0] effCode;
  logic [CODE_W-1:0] shiftIdx;
  logic              divHeld;
  logic              divRun;
  logic              fire;

  // Codes 1 and 2 fold onto the slower 128/256 periods
  always_comb begin
    case (rateCode)
      CODE_W'(1): effCode = REMAP_LO;
      CODE_W'(2): effCode = REMAP_HI;
      default:    effCode = rateCode;
    endcase
  end

  assign shiftIdx = effCode - 1'b1;
  assign divHeld  = &divCtl[DCTL_W-1:DCTL_W-2];
  assign divRun   = (divCtl <= RUN_MAX);

  assign ctrl.countClr = divHeld;
  assign ctrl.countEn  = baseStrobe & divRun;

  assign fire = baseStrobe & divRun & periodicEnable &
                (rateCode != '0) & boundary[shiftIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick    <= 1'b0;
      flagSet <= 1'b0;
      irqReq  <= 1'b0;
    end else begin
      tick    <= fire;
      flagSet <= fire;
      if (fire) begin
        irqReq <= 1'b1;
      end else if (irqClear) begin
        irqReq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pid_periodic_divider.sv
module pid_periodic_divider
  import pid_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                baseStrobe,
  input  logic [RATE_W-1:0]   rateCode,
  input  logic                periodicEnable,
  input  logic [DIVCTL_W-1:0] divCtl,
  input  logic                irqClear,
  output logic                tick,
  output logic                flagSet,
  output logic                irqReq
);

  presc_ctrl_t           prescCtrl;
  logic [PRESCALE_W:0]   boundary;

  pid_prescaler #(.CNT_W(PRESCALE_W)) presc_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (prescCtrl),
    .boundary (boundary)
  );

  pid_control #(
    .CNT_W  (PRESCALE_W),
    .CODE_W (RATE_W),
    .DCTL_W (DIVCTL_W)
  ) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .baseStrobe     (baseStrobe),
    .rateCode       (rateCode),
    .periodicEnable (periodicEnable),
    .divCtl         (divCtl),
    .irqClear       (irqClear),
    .boundary       (boundary),
    .ctrl           (prescCtrl),
    .tick           (tick),
    .flagSet        (flagSet),
    .irqReq         (irqReq)
  );

endmodule

// File: rtl/pid_periodic_divider_chk.sv
module pid_periodic_divider_chk (
  input logic       clk,
  input logic       rstN,
  input logic       baseStrobe,
  input logic [3:0] rateCode,
  input logic       periodicEnable,
  input logic [2:0] divCtl,
  input logic       irqClear,
  input logic       tick,
  input logic       flagSet,
  input logic       irqReq
);

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R9
  tick_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tick) |-> $past(baseStrobe));

  // R6
  tick_flag_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (flagSet && irqReq));

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqClear) |=> irqReq);

  // R1
  code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 4'd0) |=> !tick);

  // R5
  enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !periodicEnable |=> !flagSet);

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divCtl[2:1] == 2'b11) |=> !tick);

  // R11
  div_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divCtl > 3'd2) |=> !tick);

endmodule

bind pid_periodic_divider pid_periodic_divider_chk chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .baseStrobe     (baseStrobe),
  .rateCode       (rateCode),
  .periodicEnable (periodicEnable),
  .divCtl         (divCtl),
  .irqClear       (irqClear),
  .tick           (tick),
  .flagSet        (flagSet),
  .irqReq         (irqReq)
);

// File: tb/pid_periodic_divider_tb_top.sv
module pid_periodic_divider_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseStrobe = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       periodicEnable = 1'b0;
  logic [2:0] divCtl = 3'b110;
  logic       irqClear = 1'b0;
  logic       tick;
  logic       flagSet;
  logic       irqReq;

  int checks = 0;
  int fails = 0;
  int benchCnt = 0;
  int extraTick = 0;
  logic lastTick = 1'b0;
  logic lastFlag = 1'b0;
  bit done = 1'b0;

  // {rate code, expected period in strobes}
  localparam int VEC_N = 15;
  localparam int vecTbl [0:VEC_N-1][0:1] = '{
    '{3, 4}, '{4, 8}, '{5, 16}, '{6, 32}, '{7, 64}, '{8, 128},
    '{9, 256}, '{10, 512}, '{11, 1024}, '{12, 2048}, '{13, 4096},
    '{14, 8192}, '{15, 16384}, '{1, 128}, '{2, 256}
  };

  always #2 clk = ~clk;

  pid_periodic_divider dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .baseStrobe     (baseStrobe),
    .rateCode       (rateCode),
    .periodicEnable (periodicEnable),
    .divCtl         (divCtl),
    .irqClear       (irqClear),
    .tick           (tick),
    .flagSet        (flagSet),
    .irqReq         (irqReq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // One strobe cycle, then a quiet cycle that must show no tick
  task automatic pulse(input logic clr);
    @(negedge clk);
    baseStrobe = 1'b1;
    irqClear = clr;
    @(negedge clk);
    baseStrobe = 1'b0;
    irqClear = 1'b0;
    lastTick = tick;
    lastFlag = flagSet;
    if (divCtl[2:1] == 2'b11) benchCnt = 0;
    else if (divCtl <= 3'd2) benchCnt = (benchCnt + 1) % 32768;
    @(negedge clk);
    if (tick) extraTick++;
  endtask

  task automatic countToTick(input int maxN, output int n);
    n = -1;
    for (int i = 1; i <= maxN; i++) begin
      pulse(1'b0);
      if (lastTick) begin
        n = i;
        break;
      end
    end
  endtask

  function automatic int distTo(input int p);
    return p - (benchCnt % p);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int e;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(tick == 1'b0 && flagSet == 1'b0 && irqReq == 1'b0, "R10",
          {tick, flagSet, irqReq}, 0);
    rstN = 1'b1;
    pulse(1'b0);
    benchCnt = 0;

    // Table walk: R2 / R3 period from release, aligned to multiples (R4)
    for (int v = 0; v < VEC_N; v++) begin
      divCtl = 3'b110;
      pulse(1'b0);
      rateCode = 4'(vecTbl[v][0]);
      periodicEnable = 1'b1;
      divCtl = 3'b010;
      countToTick(vecTbl[v][1] + 2, n);
      check(n == vecTbl[v][1], (vecTbl[v][0] <= 2) ? "R3" : "R2", n, vecTbl[v][1]);
      if (v == 0) check(lastFlag == 1'b1 && irqReq == 1'b1, "R6", lastFlag, 1);
    end

    // R1: code 0 never ticks
    rateCode = 4'd0;
    countToTick(300, n);
    check(n == -1, "R1", n, -1);

    // R5: disabled, prescaler keeps running
    rateCode = 4'd3;
    periodicEnable = 1'b0;
    countToTick(41, n);
    check(n == -1, "R5", n, -1);
    periodicEnable = 1'b1;
    e = distTo(4);
    countToTick(10, n);
    check(n == e, "R5", n, e);

    // R7: rate change aligns to the new period
    pulse(1'b0);
    rateCode = 4'd5;
    e = distTo(16);
    countToTick(40, n);
    check(n == e, "R7", n, e);
    rateCode = 4'd4;
    pulse(1'b0);
    pulse(1'b0);
    pulse(1'b0);
    e = distTo(8);
    countToTick(20, n);
    check(n == e, "R4", n, e);

    // R6: request held, then cleared
    rateCode = 4'd6;
    pulse(1'b0);
    pulse(1'b0);
    check(irqReq == 1'b1, "R6", irqReq, 1);
    @(negedge clk);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    check(irqReq == 1'b0, "R6", irqReq, 0);

    // R6: set wins over a simultaneous clear
    rateCode = 4'd3;
    e = distTo(4);
    for (int i = 1; i < e; i++) pulse(1'b0);
    pulse(1'b1);
    check(lastTick == 1'b1 && irqReq == 1'b1, "R6", irqReq, 1);

    // R11: freeze keeps count, no ticks
    pulse(1'b0);
    divCtl = 3'b100;
    countToTick(20, n);
    check(n == -1, "R11", n, -1);
    divCtl = 3'b001;
    e = distTo(4);
    countToTick(10, n);
    check(n == e, "R11", n, e);

    // R8: hold clears and keeps prescaler at zero
    pulse(1'b0);
    divCtl = 3'b111;
    countToTick(30, n);
    check(n == -1, "R8", n, -1);
    divCtl = 3'b000;
    countToTick(10, n);
    check(n == 4, "R8", n, 4);

    // R9: never a tick in the quiet cycle after a strobe
    check(extraTick == 0, "R9", extraTick, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule